// File: doc/BRIEF.md
# Selectable Timer Clock Prescaler

This block makes the count-enable pulse for an 8-bit timer. A free-running 10-bit prescaler counter advances once per base tick. The base tick comes from one of two single-cycle enable inputs in the block's own clock domain: one stands for the system I/O clock and the other for a slow external oscillator, such as a 32.768 kHz watch crystal. A mode input picks between them. A 3-bit select field chooses what reaches the timer. It can choose nothing, every base tick, or a divided rate of 1/8, 1/32, 1/64, 1/128, 1/256 or 1/1024.

Software can clear the prescaler with a self-clearing command bit, so the phase of the divided tick is known after the clear. With the system source selected, the clear happens at once and the bit reads back as zero. With the external source selected, the clear waits for the next external tick. Until then the bit reads back as one, which lets software poll for completion.

The block has no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `tmr_prescaler`

## Requirements
- R1: While `rst_n` is low and after it is released, the prescaler counter is zero, `prs_rdata_o` is 0, and `tick_o` is 0 when `clk_sel_i` is 0.
- R2: With `clk_sel_i` = 0, `tick_o` never asserts.
- R3: With `clk_sel_i` = 1, `tick_o` equals the selected base tick in the same cycle.
- R4: Select codes 2, 3, 4, 5, 6 and 7 divide by 8, 32, 64, 128, 256 and 1024. With a divisor of 2^k, `tick_o` is a one-cycle pulse on a base tick during which the low k counter bits are all ones. After a clear, this is the N-th, 2N-th, and so on, base tick.
- R5: When `async_sel_i` = 0, only `sys_tick_i` advances the counter. When it is 1, only `ext_tick_i` does. The input that is not selected has no effect on `tick_o`.
- R6: In system mode (`async_sel_i` = 0), a clock edge with `prs_wr_i` = 1 and `prs_wdata_i` = 1 clears the counter, and `prs_rdata_o` always reads 0.
- R7: A write with `prs_wdata_i` = 0 changes neither the counter nor the pending state.
- R8: In external mode, a write of 1 makes `prs_rdata_o` read 1 from the next cycle on. It stays at 1 until a cycle with `ext_tick_i` high. At that edge the counter is cleared, and the bit reads 0 from the next cycle on. If the write and the tick fall in the same cycle, the clear completes in that cycle.
- R9: In the cycle where a clear takes effect, a divided tick is suppressed. An undivided tick (code 1) still passes.
- R10: A change of `clk_sel_i` applies from the current cycle on and does not clear the counter.
- R11: A clear that is still pending when `async_sel_i` returns to 0 completes at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_tick_i | input | 1 | Base tick enable from the system I/O clock |
| ext_tick_i | input | 1 | Base tick enable from the external oscillator |
| async_sel_i | input | 1 | 1 = external oscillator is the base source |
| clk_sel_i | input | 3 | 0 stop, 1 undivided, 2..7 = /8 /32 /64 /128 /256 /1024 |
| prs_wr_i | input | 1 | Write strobe for the prescaler clear bit |
| prs_wdata_i | input | 1 | Value written to the clear bit |
| prs_rdata_o | output | 1 | Read value of the clear bit |
| tick_o | output | 1 | Count-enable pulse for the timer |

## Verification
The hardest case to reach is a clear that is held pending in external mode. It needs a write of 1 while `ext_tick_i` stays low for many cycles, and then either a late external tick or a switch back to system mode while the clear is still waiting. Directed phases hold `ext_tick_i` low across a long window and end it both ways. The /1024 tap also needs over a thousand base ticks with no clear in between. For this reason the random phase keeps the select field and the mode stable for long stretches, drives the system tick at a high rate, and makes writes rare.

// File: rtl/tmr_prescaler_pkg.sv
package tmr_prescaler_pkg;

  // Number of low counter bits that must be all ones for a given select code.
  // Codes 0 and 1 have no tap and return 0.
  function automatic int tap_shift(input int code);
    case (code)
      2:       tap_shift = 3;
      3:       tap_shift = 5;
      4:       tap_shift = 6;
      5:       tap_shift = 7;
      6:       tap_shift = 8;
      7:       tap_shift = 10;
      default: tap_shift = 0;
    endcase
  endfunction

  typedef enum logic [2:0] {
    SEL_STOP  = 3'd0,
    SEL_UNDIV = 3'd1
  } sel_code_e;

endpackage

// File: rtl/tmr_prescaler_src_mux.sv
module tmr_prescaler_src_mux (
  input  logic sys_tick_i,
  input  logic ext_tick_i,
  input  logic async_sel_i,
  output logic base_tick_o
);
  // Both sources are tick enables in the same clock domain.
  always_comb begin
    base_tick_o = async_sel_i ? ext_tick_i : sys_tick_i;
  end
endmodule

// File: rtl/tmr_prescaler_clr_ctl.sv
module tmr_prescaler_clr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick_i,
  input  logic async_sel_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic clr_o,
  output logic rdata_o
);
  logic pend_q;
  logic pend_eff;

  always_comb begin
    // A write of zero leaves the pending state alone.
    pend_eff = pend_q | (wr_i & wdata_i);
    if (async_sel_i) begin
      clr_o = pend_eff & base_tick_i;
    end else begin
      clr_o = pend_eff;
    end
    rdata_o = pend_q & async_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (async_sel_i) begin
      pend_q <= pend_eff & ~base_tick_i;
    end else begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_prescaler_counter.sv
module tmr_prescaler_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_prescaler_tap_sel.sv
module tmr_prescaler_tap_sel
  import tmr_prescaler_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int SEL_W = 3
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             base_tick_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int NCODE = 1 << SEL_W;

  logic [NCODE-1:0] wrap;

  for (genvar g = 0; g < NCODE; g++) begin : g_tap
    localparam int SH = tap_shift(g);
    if (SH > 0 && SH <= CNT_W) begin : g_div
      assign wrap[g] = &cnt_i[SH-1:0];
    end else begin : g_none
      assign wrap[g] = 1'b0;
    end
  end

  always_comb begin
    if (sel_i == SEL_UNDIV) begin
      tick_o = base_tick_i;
    end else begin
      // Divided taps are held back in a clearing cycle.
      tick_o = base_tick_i & wrap[sel_i] & ~clr_i;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CNT_W = 10,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_tick_i,
  input  logic             ext_tick_i,
  input  logic             async_sel_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             prs_wr_i,
  input  logic             prs_wdata_i,
  output logic             prs_rdata_o,
  output logic             tick_o
);
  logic             base_tick;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  tmr_prescaler_src_mux u_src (
    .sys_tick_i  (sys_tick_i),
    .ext_tick_i  (ext_tick_i),
    .async_sel_i (async_sel_i),
    .base_tick_o (base_tick)
  );

  tmr_prescaler_clr_ctl u_clr (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_tick_i (base_tick),
    .async_sel_i (async_sel_i),
    .wr_i        (prs_wr_i),
    .wdata_i     (prs_wdata_i),
    .clr_o       (clr),
    .rdata_o     (prs_rdata_o)
  );

  tmr_prescaler_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (base_tick),
    .clr_i (clr),
    .cnt_o (cnt)
  );

  tmr_prescaler_tap_sel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tap (
    .cnt_i       (cnt),
    .sel_i       (clk_sel_i),
    .base_tick_i (base_tick),
    .clr_i       (clr),
    .tick_o      (tick_o)
  );
endmodule

// File: rtl/tmr_prescaler_chk.sv
module tmr_prescaler_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_tick_i,
  input logic             ext_tick_i,
  input logic             async_sel_i,
  input logic [SEL_W-1:0] clk_sel_i,
  input logic             prs_wr_i,
  input logic             prs_wdata_i,
  input logic             prs_rdata_o,
  input logic             tick_o
);
  logic src_tick;
  assign src_tick = async_sel_i ? ext_tick_i : sys_tick_i;

  a_r2_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == '0) |-> !tick_o);

  a_r3_undiv_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == 1) |-> (tick_o == src_tick));

  a_r5_tick_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> src_tick);

  a_r6_sync_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !async_sel_i |-> !prs_rdata_o);

  a_r8_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    (async_sel_i && prs_wr_i && prs_wdata_i && !ext_tick_i) |=> (prs_rdata_o || !async_sel_i));

  a_r8_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (async_sel_i && prs_rdata_o && !ext_tick_i) |=> (prs_rdata_o || !async_sel_i));

  a_r8_pending_done: assert property (@(posedge clk) disable iff (!rst_n)
    (async_sel_i && prs_rdata_o && ext_tick_i) |=> !prs_rdata_o);
endmodule

bind tmr_prescaler tmr_prescaler_chk #(.SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_tick_i  (sys_tick_i),
  .ext_tick_i  (ext_tick_i),
  .async_sel_i (async_sel_i),
  .clk_sel_i   (clk_sel_i),
  .prs_wr_i    (prs_wr_i),
  .prs_wdata_i (prs_wdata_i),
  .prs_rdata_o (prs_rdata_o),
  .tick_o      (tick_o)
);

// File: tb/tmr_prescaler_tb_top.sv
module tmr_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       async_sel = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       wr = 1'b0;
  logic       wd = 1'b0;
  logic       rdata;
  logic       tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] m_cnt = '0;
  logic       m_pend = 1'b0;

  always #4 clk = ~clk;

  tmr_prescaler dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_tick_i  (sys_tick),
    .ext_tick_i  (ext_tick),
    .async_sel_i (async_sel),
    .clk_sel_i   (sel),
    .prs_wr_i    (wr),
    .prs_wdata_i (wd),
    .prs_rdata_o (rdata),
    .tick_o      (tick)
  );

  function automatic int div_bits(input logic [2:0] s);
    case (s)
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 6;
      3'd5: return 7;
      3'd6: return 8;
      3'd7: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic low_ones(input logic [9:0] c, input int k);
    logic [9:0] mask;
    mask = (10'd1 << k) - 10'd1;
    if (k == 10) mask = 10'h3ff;
    return ((c & mask) == mask);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic st, input logic et, input logic as_i,
                      input logic [2:0] s, input logic w, input logic d,
                      input string tag);
    logic base, pe, dorst, etick, nxt_pend;
    logic [9:0] nxt_cnt;
    string tt, rt;
    @(negedge clk);
    sys_tick = st; ext_tick = et; async_sel = as_i; sel = s; wr = w; wd = d;
    #1;
    base  = as_i ? et : st;
    pe    = m_pend | (w & d);
    dorst = as_i ? (pe & base) : pe;
    if (s == 3'd0)      etick = 1'b0;
    else if (s == 3'd1) etick = base;
    else                etick = base & !dorst & low_ones(m_cnt, div_bits(s));
    if (tag != "") begin
      tt = tag; rt = tag;
    end else begin
      tt = (s == 3'd0) ? "R2" : (s == 3'd1) ? "R3" : dorst ? "R9" : "R4";
      rt = as_i ? "R8" : "R6";
    end
    check(tt, tick, etick);
    check(rt, rdata, m_pend & as_i);
    nxt_cnt  = dorst ? 10'd0 : (base ? m_cnt + 10'd1 : m_cnt);
    nxt_pend = as_i ? (pe & !base) : 1'b0;
    @(posedge clk);
    m_cnt = nxt_cnt;
    m_pend = nxt_pend;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int cur_sel, cur_as;
    void'($urandom(32'h5eed_2024));
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1", tick, 1'b0);
    check("R1", rdata, 1'b0);
    rst_n = 1'b1;
    // R1 and R4: first /8 pulse on the 8th tick after reset
    for (int i = 0; i < 24; i++) step(1, 0, 0, 3'd2, 0, 0, "R1");
    // R3 undivided with a gapped system tick
    for (int i = 0; i < 10; i++) step(i[0], 0, 0, 3'd1, 0, 0, "R3");
    // R5: system mode ignores the external tick, and external mode ignores the system tick
    for (int i = 0; i < 12; i++) step(0, 1, 0, 3'd1, 0, 0, "R5");
    for (int i = 0; i < 12; i++) step(1, 0, 1, 3'd1, 0, 0, "R5");
    for (int i = 0; i < 40; i++) step(0, 1, 1, 3'd2, 0, 0, "R5");
    // R6: immediate clear in system mode, then the /32 phase restarts
    step(1, 0, 0, 3'd3, 1, 1, "R6");
    for (int i = 0; i < 40; i++) step(1, 0, 0, 3'd3, 0, 0, "R6");
    // R7: writes of zero have no effect in either mode
    for (int i = 0; i < 20; i++) step(1, 0, 0, 3'd2, 1, 0, "R7");
    for (int i = 0; i < 20; i++) step(0, 1, 1, 3'd2, 1, 0, "R7");
    // R8: the clear stays pending over a long gap in the external tick
    step(0, 0, 1, 3'd2, 1, 1, "R8");
    for (int i = 0; i < 30; i++) step(0, 0, 1, 3'd2, 0, 0, "R8");
    step(0, 1, 1, 3'd2, 0, 0, "R9");
    for (int i = 0; i < 20; i++) step(0, 1, 1, 3'd2, 0, 0, "R8");
    // R8: a write that meets an external tick completes at once
    step(0, 1, 1, 3'd2, 1, 1, "R8");
    for (int i = 0; i < 10; i++) step(0, 1, 1, 3'd2, 0, 0, "R8");
    // R11: the pending clear completes when the mode drops back to system
    step(0, 0, 1, 3'd2, 1, 1, "R11");
    step(0, 0, 1, 3'd2, 0, 0, "R11");
    step(1, 0, 0, 3'd2, 0, 0, "R11");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 3'd2, 0, 0, "R11");
    // R10: a select change keeps the counter phase
    for (int i = 0; i < 5; i++) step(1, 0, 0, 3'd2, 0, 0, "R10");
    for (int i = 0; i < 70; i++) step(1, 0, 0, 3'd4, 0, 0, "R10");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 3'd2, 0, 0, "R10");
    // R4: full /1024 period
    step(1, 0, 0, 3'd7, 1, 1, "R6");
    for (int i = 0; i < 2100; i++) step(1, 0, 0, 3'd7, 0, 0, "");
    // Random phase
    cur_sel = 2; cur_as = 0;
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(399) == 0) cur_sel = $urandom_range(7);
      if ($urandom_range(699) == 0) cur_as = $urandom_range(1);
      step(($urandom_range(7) != 0), ($urandom_range(3) == 0), cur_as[0],
           cur_sel[2:0], ($urandom_range(149) == 0), $urandom_range(1), "");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule